// File: doc/BRIEF.md
# Tracking-Error Built-In-Test Monitor

This block supervises a tracking angle converter loop. It takes the signed tracking error that the loop reports, in LSBs, and raises a fault when the magnitude of that error reaches a threshold and stays there without a break for a fixed persistence window. The default window is 500 µs of clock cycles, set as a clock rate in MHz times a window length in µs. Two digitised flags are OR-combined into the same fault. One reports that the sensor signal amplitude has been lost and the other that the excitation reference has been lost. Neither flag is filtered. The result is a single active-low line: 1 means healthy and 0 means fault.

A large error is normal for a short time after a step in angle or at power-up. The persistence window keeps those transients off the line. An error that outlasts the window is reported, as is any loss flag.

The design has two state machines. The persistence filter has three states. FS_CLEAR means the error is below threshold and the count is zero. FS_FILTER means the error is over threshold and counting. FS_TRIPPED means the count has reached the window length. Its transitions are:
- CLEAR→FILTER on an over-threshold sample.
- FILTER→FILTER while the error stays over and the window is not yet complete.
- FILTER→TRIPPED when the count completes.
- TRIPPED→TRIPPED while the error stays over.
- FILTER→CLEAR and TRIPPED→CLEAR on any sample below threshold.

The output machine has two states, OS_HEALTHY and OS_FAULT. It moves HEALTHY→FAULT when the filter trips or either loss flag is set. It moves FAULT→HEALTHY on the first edge at which all three causes are clear.

Top module: `bitmon_top`

## Requirements
- R1: While reset is high and on the first cycle after it is released, `bit_n` is 1 and the persistence count is zero.
- R2: `bit_n` is active low. It goes to 0 only when a fault cause was present at the preceding clock edge.
- R3: A positive error whose value is at least `THRESH_LSB` counts as over threshold.
- R4: A negative error whose value is at most `-THRESH_LSB` counts as over threshold. This includes the most negative code of the two's-complement error word.
- R5: An error with magnitude at most `THRESH_LSB-1` never drives `bit_n` to 0, however long it lasts.
- R6: With the error over threshold at N consecutive rising edges, `bit_n` falls at edge N = FILT_CYCLES and not earlier. FILT_CYCLES is CLK_MHZ·FILT_US.
- R7: A single edge that samples the error below threshold resets the persistence count to zero. A full new window is then needed before a fault.
- R8: `sig_lost` high at a rising edge drives `bit_n` to 0 at that edge, whatever the error.
- R9: `ref_lost` high at a rising edge drives `bit_n` to 0 at that edge, whatever the error.
- R10: `bit_n` returns to 1 at the first rising edge at which the error is below threshold and both loss flags are low.
- R11: After an error fault, `bit_n` stays 0 for as long as the error stays over threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| trk_err | input | ERR_W | Signed two's-complement tracking error in LSBs |
| sig_lost | input | 1 | Sensor signal amplitude lost, active high |
| ref_lost | input | 1 | Excitation reference amplitude lost, active high |
| bit_n | output | 1 | Built-in-test fault line, 0 = fault |

## Verification
A loss flag shows on `bit_n` at the same rising edge that samples it. Recovery likewise shows at the first edge with all causes clear. An error fault shows at exactly the FILT_CYCLES-th consecutive over-threshold edge.

The bench drives every input on a falling edge and samples on a falling edge. It counts the rising edges in between, so it reads each result half a cycle after the edge where it is due. In the error sweep it also reads the edge just before the due edge, which proves the fault is not early.

// File: rtl/bitmon_pkg.sv
package bitmon_pkg;

    typedef enum logic [1:0] {
        FS_CLEAR   = 2'd0,
        FS_FILTER  = 2'd1,
        FS_TRIPPED = 2'd2
    } filt_state_e;

    typedef enum logic {
        OS_HEALTHY = 1'b0,
        OS_FAULT   = 1'b1
    } out_state_e;

endpackage

// File: rtl/bitmon_mag.sv
module bitmon_mag #(
    parameter int ERR_W  = 16,
    parameter int THRESH = 100
) (
    input  logic [ERR_W-1:0] err,
    output logic             over
);
    localparam int MAG_W = ERR_W + 1;
    localparam logic [MAG_W-1:0] THR_V = MAG_W'(THRESH);

    logic [MAG_W-1:0] ext;
    logic [MAG_W-1:0] mag;

    // one extra bit keeps the most negative code's magnitude representable
    always_comb begin
        ext = {err[ERR_W-1], err};
        if (ext[MAG_W-1]) begin
            mag = ~ext + 1'b1;
        end else begin
            mag = ext;
        end
        over = (mag >= THR_V);
    end
endmodule

// File: rtl/bitmon_filter.sv
module bitmon_filter
    import bitmon_pkg::*;
#(
    parameter int FILT_CYCLES = 125000,
    parameter int CNT_W       = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             over,
    output logic [CNT_W-1:0] cnt,
    output logic             trip_d
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FILT_CYCLES);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    filt_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FS_CLEAR: begin
                if (over) begin
                    cnt_d   = ONE;
                    state_d = (ONE == LIMIT) ? FS_TRIPPED : FS_FILTER;
                end
            end
            FS_FILTER: begin
                if (!over) begin
                    cnt_d   = '0;
                    state_d = FS_CLEAR;
                end else begin
                    cnt_d = cnt_q + ONE;
                    if (cnt_q + ONE == LIMIT) begin
                        state_d = FS_TRIPPED;
                    end
                end
            end
            FS_TRIPPED: begin
                if (!over) begin
                    cnt_d   = '0;
                    state_d = FS_CLEAR;
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = FS_CLEAR;
            end
        endcase
    end

    always_comb begin
        cnt    = cnt_q;
        trip_d = (state_d == FS_TRIPPED);
    end
endmodule

// File: rtl/bitmon_flag.sv
module bitmon_flag
    import bitmon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trip_d,
    input  logic sig_lost,
    input  logic ref_lost,
    output logic bit_n
);
    out_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OS_HEALTHY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            OS_HEALTHY: state_d = (trip_d || sig_lost || ref_lost) ? OS_FAULT : OS_HEALTHY;
            OS_FAULT:   state_d = (trip_d || sig_lost || ref_lost) ? OS_FAULT : OS_HEALTHY;
            default:    state_d = OS_HEALTHY;
        endcase
    end

    always_comb begin
        bit_n = (state_q == OS_HEALTHY);
    end
endmodule

// File: rtl/bitmon_top.sv
module bitmon_top #(
    parameter int ERR_W      = 16,
    parameter int THRESH_LSB = 100,
    parameter int CLK_MHZ    = 250,
    parameter int FILT_US    = 500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ERR_W-1:0] trk_err,
    input  logic             sig_lost,
    input  logic             ref_lost,
    output logic             bit_n
);
    localparam int FILT_CYCLES = CLK_MHZ * FILT_US;
    localparam int CNT_W       = $clog2(FILT_CYCLES + 1);

    logic             over;
    logic [CNT_W-1:0] filt_cnt;
    logic             trip_d;

    bitmon_mag #(
        .ERR_W (ERR_W),
        .THRESH(THRESH_LSB)
    ) u_mag (
        .err (trk_err),
        .over(over)
    );

    bitmon_filter #(
        .FILT_CYCLES(FILT_CYCLES),
        .CNT_W      (CNT_W)
    ) u_filter (
        .clk   (clk),
        .rst   (rst),
        .over  (over),
        .cnt   (filt_cnt),
        .trip_d(trip_d)
    );

    bitmon_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .trip_d  (trip_d),
        .sig_lost(sig_lost),
        .ref_lost(ref_lost),
        .bit_n   (bit_n)
    );
endmodule

// File: rtl/bitmon_chk.sv
module bitmon_chk #(
    parameter int FILT_CYCLES = 125000,
    parameter int CNT_W       = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             sig_lost,
    input logic             ref_lost,
    input logic             bit_n,
    input logic             over,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FILT_CYCLES);

    AST_RESET_HEALTHY: assert property (@(posedge clk) rst |=> (bit_n && cnt == '0)); // R1
    AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !bit_n |-> $past(over || sig_lost || ref_lost)); // R2
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= LIMIT); // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (over && cnt < LIMIT) |=> (cnt == $past(cnt) + 1'b1)); // R6
    AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        !over |=> (cnt == '0)); // R7
    AST_SIG_LOSS_TRIPS: assert property (@(posedge clk) disable iff (rst) sig_lost |=> !bit_n); // R8
    AST_REF_LOSS_TRIPS: assert property (@(posedge clk) disable iff (rst) ref_lost |=> !bit_n); // R9
    AST_CLEAR_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!over && !sig_lost && !ref_lost) |=> bit_n); // R10
    AST_ERR_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt == LIMIT && over) |=> (cnt == LIMIT && !bit_n)); // R11
endmodule

bind bitmon_top bitmon_chk #(
    .FILT_CYCLES(FILT_CYCLES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sig_lost(sig_lost),
    .ref_lost(ref_lost),
    .bit_n   (bit_n),
    .over    (over),
    .cnt     (filt_cnt)
);

// File: tb/bitmon_top_bench.sv
`timescale 1ns/1ps
module bitmon_top_bench;
    localparam int ERR_W = 10;
    localparam int TH    = 20;
    localparam int FILT  = 6;   // CLK_MHZ 2 * FILT_US 3

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [ERR_W-1:0] trk_err = '0;
    logic             sig_lost = 1'b0;
    logic             ref_lost = 1'b0;
    logic             bit_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bitmon_top #(
        .ERR_W     (ERR_W),
        .THRESH_LSB(TH),
        .CLK_MHZ   (2),
        .FILT_US   (3)
    ) u_bitmon_top (
        .clk     (clk),
        .rst     (rst),
        .trk_err (trk_err),
        .sig_lost(sig_lost),
        .ref_lost(ref_lost),
        .bit_n   (bit_n)
    );

    task automatic chk(input string tag, input logic act, input logic exp, input int v);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s err=%0d bit_n actual=%b expected=%b", tag, v, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        edges(1);
        chk("R1", bit_n, 1'b1, 0);
        edges(2);
        rst = 1'b0;
        edges(1);
        chk("R1", bit_n, 1'b1, 0);

        // sweep every error code
        for (int v = -(1 << (ERR_W - 1)); v < (1 << (ERR_W - 1)); v++) begin
            logic exp_over;
            string tag;
            exp_over = (v >= TH) || (v <= -TH);
            tag = !exp_over ? "R5" : (v < 0 ? "R4" : "R3");
            trk_err = ERR_W'(v);
            edges(FILT - 1);
            chk("R6", bit_n, 1'b1, v);
            edges(1);
            chk(tag, bit_n, !exp_over, v);
            edges(1);
            chk("R11", bit_n, !exp_over, v);
            trk_err = '0;
            edges(1);
            chk("R10", bit_n, 1'b1, v);
        end

        // interruption restarts the window
        trk_err = ERR_W'(TH + 5);
        edges(FILT - 1);
        trk_err = ERR_W'(TH - 1);
        edges(1);
        chk("R7", bit_n, 1'b1, TH - 1);
        trk_err = ERR_W'(-TH);
        edges(FILT - 1);
        chk("R7", bit_n, 1'b1, -TH);
        edges(1);
        chk("R7", bit_n, 1'b0, -TH);
        trk_err = '0;
        edges(1);
        chk("R10", bit_n, 1'b1, 0);

        // loss flags
        sig_lost = 1'b1;
        edges(1);
        chk("R8", bit_n, 1'b0, 0);
        edges(3);
        chk("R8", bit_n, 1'b0, 0);
        sig_lost = 1'b0;
        edges(1);
        chk("R10", bit_n, 1'b1, 0);
        ref_lost = 1'b1;
        edges(1);
        chk("R9", bit_n, 1'b0, 0);
        ref_lost = 1'b0;
        edges(1);
        chk("R10", bit_n, 1'b1, 0);

        // loss released while the error window is still running
        trk_err = ERR_W'(TH);
        sig_lost = 1'b1;
        edges(2);
        chk("R8", bit_n, 1'b0, TH);
        sig_lost = 1'b0;
        edges(1);
        chk("R6", bit_n, 1'b1, TH);
        edges(FILT - 3);
        chk("R6", bit_n, 1'b0, TH);
        ref_lost = 1'b1;
        trk_err = '0;
        edges(1);
        chk("R9", bit_n, 1'b0, 0);
        ref_lost = 1'b0;
        edges(1);
        chk("R10", bit_n, 1'b1, 0);

        // reset in the middle of a fault
        sig_lost = 1'b1;
        edges(1);
        rst = 1'b1;
        sig_lost = 1'b0;
        edges(1);
        chk("R1", bit_n, 1'b1, 0);
        rst = 1'b0;
        edges(1);
        chk("R1", bit_n, 1'b1, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule